// File: doc/BRIEF.md
# Two-Phase Bit-Serial Static Memory

This block is a synthesizable behavioural model of a 128-cell static memory arranged as 16 word lines by 8 bitline pairs. It is accessed one bit at a time. Each access takes two phases. In the precharge phase every bitline pair is pulled high and equalised, and the operation (read strobe, write strobe, address and data bit) is captured. In the evaluation phase exactly one word line rises and is gated by the evaluation phase. During that phase the selected pair is either driven by the write driver or observed by a sensing stage.

The two phases arrive as level inputs that a system clock samples. They are expected never to be high together and each to be high for about 40% of an access period. If they do overlap, the precharge phase wins. The 7-bit address splits into a row field and a column field. The row field feeds a predecoded row decoder. The column field feeds a one-hot column select that plays the part of the pass switches. The data output is a holding latch, loaded only when an evaluation with a resolved sense ends.

Top module: `bitserial_sram`

## Requirements
- R1: Address bits [3:0] select the word line (word line n is `wordline[n]`) and bits [6:4] select the bitline pair. A bit written at an address is returned by a later read of the same address, and a write to one column leaves the other cells of that row unchanged.
- R2: At most one bit of `wordline` is high at any time.
- R3: No word line is high while `phi_pre` is high or while `phi_eval` is low.
- R4: Every clock with `phi_pre` high leaves all bitline pairs high, so back-to-back reads of cells holding opposite values each return their own value.
- R5: During a write evaluation the selected true bitline follows the input bit and its complement is the inverse, and the addressed cell takes the input bit.
- R6: `dout` changes only on the clock edge that follows the end of an evaluation phase in which the sensing stage resolved a value.
- R7: The sensing stage is on only while `sense_en`, `phi_eval` and a captured read are all present. A read evaluated with `sense_en` low leaves `dout` unchanged.
- R8: When both strobes are high at capture, the access is a write: the cell takes `din` and `dout` is not updated.
- R9: When neither strobe is high at capture, no word line rises during the evaluation phase, no cell changes and `dout` holds.
- R10: While `rst_n` is low, `dout` is 0, no word line is high, every cell reads back as 0 and all bitlines are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi_pre | input | 1 | Precharge phase level; operation capture window |
| phi_eval | input | 1 | Evaluation phase level; gates word lines |
| addr | input | 7 | Bit address, row in [3:0], column in [6:4] |
| din | input | 1 | Write data bit |
| rd_stb | input | 1 | Read strobe, sampled during precharge |
| wr_stb | input | 1 | Write strobe, sampled during precharge; wins over read |
| sense_en | input | 1 | Sense enable, effective only during a read evaluation |
| dout | output | 1 | Held output bit from the last resolved read |
| wordline | output | 16 | Gated word lines, at most one high |

## Verification
The bench goes after the cases where a row or column field is swapped or mis-sliced. A design with that fault raises the wrong word line or reads back a neighbouring cell's bit, which shows up as a failed full-array pattern check. It also alternates reads of opposite values. A model that skips precharge would then leave both bitlines discharged and return the stale value. Finally, it probes strobe collisions, reads without sense, and idle accesses. A design that favours the read, or lets an unsensed or idle evaluation reach the latch or the array, would then change `dout` or corrupt a cell that is read back afterwards.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_kind_t;

  // Write has priority when both strobes are present.
  function automatic op_kind_t pick_op(input logic rd, input logic wr);
    if (wr) return OP_WRITE;
    if (rd) return OP_READ;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/bsram_row_decoder.sv
module bsram_row_decoder #(
  parameter int ABITS = 4,
  localparam int NLINES = 1 << ABITS,
  localparam int NGRP = (ABITS + 1) / 2,
  localparam int PADW = 2 * NGRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ABITS-1:0]  row,
  output logic [NLINES-1:0] line
);

  logic [PADW-1:0] row_pad;
  logic [3:0]      pre [NGRP];

  assign row_pad = PADW'(row);

  // Predecode stage: each pair of address bits becomes four lines.
  for (genvar g = 0; g < NGRP; g++) begin : g_pre
    assign pre[g] = 4'b0001 << row_pad[2*g +: 2];
  end

  // Output stage: one AND of predecoded lines per word line, gated by en.
  for (genvar j = 0; j < NLINES; j++) begin : g_line
    localparam logic [PADW-1:0] JP = PADW'(j);
    logic hit;
    always_comb begin
      hit = 1'b1;
      for (int g = 0; g < NGRP; g++) hit = hit & pre[g][JP[2*g +: 2]];
      line[j] = en & hit;
    end
  end

  p_single_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line));
  p_line_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (line == '0));
  p_line_matches_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> line[row]);

endmodule

// File: rtl/bsram_col_select.sv
module bsram_col_select #(
  parameter int CBITS = 3,
  localparam int NCOLS = 1 << CBITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CBITS-1:0] col,
  output logic [NCOLS-1:0] sel
);

  function automatic logic [NCOLS-1:0] one_hot(input logic [CBITS-1:0] v);
    logic [NCOLS-1:0] r;
    r = '0;
    r[v] = 1'b1;
    return r;
  endfunction

  assign sel = en ? one_hot(col) : '0;

  p_one_column_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (en == (sel != '0)));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ROWS = 16,
  parameter int COLS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            precharge,
  input  logic [ROWS-1:0] wl,
  input  logic [COLS-1:0] csel,
  input  logic            wr_en,
  input  logic            din,
  output logic            sel_t,
  output logic            sel_c
);

  logic [COLS-1:0] cells [ROWS];
  logic [COLS-1:0] bl_t;
  logic [COLS-1:0] bl_c;
  logic [COLS-1:0] row_data;
  logic            any_wl;

  // Cells of the active row drive their bitlines.
  always_comb begin
    row_data = '0;
    for (int r = 0; r < ROWS; r++)
      if (wl[r]) row_data = row_data | cells[r];
  end

  assign any_wl = |wl;

  // Pass switches: selected pair onto the shared sense/write lines.
  assign sel_t = |(csel & bl_t);
  assign sel_c = |(csel & bl_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_t <= '1;
      bl_c <= '1;
    end else if (precharge) begin
      bl_t <= '1;
      bl_c <= '1;
    end else if (any_wl) begin
      for (int c = 0; c < COLS; c++) begin
        if (wr_en && csel[c]) begin
          bl_t[c] <= din;
          bl_c[c] <= ~din;
        end else begin
          bl_t[c] <= bl_t[c] & row_data[c];
          bl_c[c] <= bl_c[c] & ~row_data[c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else if (!precharge && wr_en) begin
      for (int r = 0; r < ROWS; r++)
        if (wl[r]) cells[r] <= (cells[r] & ~csel) | (csel & {COLS{din}});
    end
  end

  p_precharge_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(precharge) |-> ((&bl_t) && (&bl_c)));
  p_write_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && any_wl && !precharge) |=>
      (((bl_t & $past(csel)) == ($past(din) ? $past(csel) : '0)) &&
       ((bl_c & $past(csel)) == ($past(din) ? '0 : $past(csel)))));

endmodule

// File: rtl/bsram_sense.sv
module bsram_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_on,
  input  logic bit_t,
  input  logic bit_c,
  input  logic eval_end,
  output logic dout
);

  logic sa_q;
  logic sa_valid;
  logic resolved;

  assign resolved = sense_on & (bit_t ^ bit_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q     <= 1'b0;
      sa_valid <= 1'b0;
      dout     <= 1'b0;
    end else if (eval_end) begin
      if (sa_valid) dout <= sa_q;
      sa_valid <= 1'b0;
    end else if (resolved) begin
      sa_q     <= bit_t;
      sa_valid <= 1'b1;
    end
  end

  p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> $past(eval_end && sa_valid));

endmodule

// File: rtl/bitserial_sram.sv
module bitserial_sram #(
  parameter int ROW_AW = 4,
  parameter int COL_AW = 3,
  localparam int ROWS = 1 << ROW_AW,
  localparam int COLS = 1 << COL_AW,
  localparam int AW = ROW_AW + COL_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            phi_pre,
  input  logic            phi_eval,
  input  logic [AW-1:0]   addr,
  input  logic            din,
  input  logic            rd_stb,
  input  logic            wr_stb,
  input  logic            sense_en,
  output logic            dout,
  output logic [ROWS-1:0] wordline
);
  import bsram_pkg::*;

  function automatic logic [ROW_AW-1:0] row_field(input logic [AW-1:0] a);
    return a[ROW_AW-1:0];
  endfunction

  function automatic logic [COL_AW-1:0] col_field(input logic [AW-1:0] a);
    return a[AW-1:ROW_AW];
  endfunction

  op_kind_t          op_q;
  logic [ROW_AW-1:0] row_q;
  logic [COL_AW-1:0] col_q;
  logic              din_q;
  logic              eval_q;

  // Named internal events.
  logic            access_on;
  logic            wr_en;
  logic            sense_on;
  logic            eval_end;
  logic [COLS-1:0] csel;
  logic            sel_t;
  logic            sel_c;

  // Operation capture: follows the inputs through the precharge phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_IDLE;
      row_q <= '0;
      col_q <= '0;
      din_q <= 1'b0;
    end else if (phi_pre) begin
      op_q  <= pick_op(rd_stb, wr_stb);
      row_q <= row_field(addr);
      col_q <= col_field(addr);
      din_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_q <= 1'b0;
    else        eval_q <= phi_eval & ~phi_pre;
  end

  assign access_on = phi_eval & ~phi_pre & (op_q != OP_IDLE);
  assign wr_en     = (op_q == OP_WRITE);
  assign sense_on  = sense_en & phi_eval & ~phi_pre & (op_q == OP_READ);
  assign eval_end  = eval_q & ~(phi_eval & ~phi_pre);

  bsram_row_decoder #(.ABITS(ROW_AW)) u_rowdec (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (access_on),
    .row  (row_q),
    .line (wordline)
  );

  bsram_col_select #(.CBITS(COL_AW)) u_colsel (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (access_on),
    .col  (col_q),
    .sel  (csel)
  );

  bsram_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .precharge(phi_pre),
    .wl       (wordline),
    .csel     (csel),
    .wr_en    (wr_en),
    .din      (din_q),
    .sel_t    (sel_t),
    .sel_c    (sel_c)
  );

  bsram_sense u_sense (
    .clk     (clk),
    .rst_n   (rst_n),
    .sense_on(sense_on),
    .bit_t   (sel_t),
    .bit_c   (sel_c),
    .eval_end(eval_end),
    .dout    (dout)
  );

  p_no_wl_precharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phi_pre || !phi_eval) |-> (wordline == '0));
  p_write_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phi_pre && wr_stb) |=> (op_q == OP_WRITE));
  p_sense_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_en || op_q != OP_READ) |-> !sense_on);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_IDLE) |-> (wordline == '0));

  always_comb begin
    if (!rst_n) begin
      p_reset_state_r10: assert (wordline == '0);
    end
  end

endmodule

// File: tb/sim_bitserial_sram.sv
`timescale 1ns/100ps
module sim_bitserial_sram;

  localparam int ROWS = 16;
  localparam int AW = 7;
  localparam int NVEC = 13;

  // Vector: [12:11] kind (0 idle, 1 read, 2 write, 3 both strobes),
  // [10:4] address, [3] din, [2] sense_en, [1] expected dout after access.
  localparam logic [12:0] VEC [NVEC] = '{
    {2'd1, 7'h00, 1'b0, 1'b1, 1'b0, 1'b0},  // reset cell reads 0 (R10)
    {2'd2, 7'h25, 1'b1, 1'b1, 1'b0, 1'b0},  // write 1, dout held (R5)
    {2'd1, 7'h25, 1'b0, 1'b1, 1'b1, 1'b0},  // read back 1 (R1)
    {2'd2, 7'h45, 1'b1, 1'b1, 1'b1, 1'b0},  // same row, other column
    {2'd1, 7'h25, 1'b0, 1'b1, 1'b1, 1'b0},  // neighbour intact (R1)
    {2'd1, 7'h05, 1'b0, 1'b1, 1'b0, 1'b0},  // other column still 0
    {2'd3, 7'h05, 1'b1, 1'b1, 1'b0, 1'b0},  // both strobes: write, dout held (R8)
    {2'd1, 7'h05, 1'b0, 1'b1, 1'b1, 1'b0},  // write took place (R8)
    {2'd1, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0},  // no sense: dout holds (R7)
    {2'd0, 7'h00, 1'b1, 1'b1, 1'b1, 1'b0},  // idle: nothing happens (R9)
    {2'd1, 7'h00, 1'b0, 1'b1, 1'b0, 1'b0},  // idle wrote nothing (R9)
    {2'd1, 7'h45, 1'b0, 1'b1, 1'b1, 1'b0},  // alternate 1 (R4)
    {2'd1, 7'h00, 1'b0, 1'b1, 1'b0, 1'b0}   // alternate 0 (R4)
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            phi_pre = 1'b0;
  logic            phi_eval = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            din = 1'b0;
  logic            rd_stb = 1'b0;
  logic            wr_stb = 1'b0;
  logic            sense_en = 1'b0;
  logic            dout;
  logic [ROWS-1:0] wordline;

  int checks = 0;
  int errors = 0;
  int bad_r2 = 0;
  int bad_r3 = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitserial_sram u0 (
    .clk(clk), .rst_n(rst_n), .phi_pre(phi_pre), .phi_eval(phi_eval),
    .addr(addr), .din(din), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .sense_en(sense_en), .dout(dout), .wordline(wordline)
  );

  // Continuous word-line monitor for R2 and R3.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!$onehot0(wordline)) bad_r2++;
      if ((phi_pre || !phi_eval) && (wordline != '0)) bad_r3++;
    end
  end

  function automatic logic pattern_bit(input logic [AW-1:0] a);
    return a[0] ^ a[3] ^ a[6] ^ (a[5] & a[1]) ^ (a[4] & ~a[2]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access: 4 clocks precharge, 1 gap, 4 clocks evaluation, 1 gap.
  task automatic access(input logic [1:0] kind, input logic [AW-1:0] a,
                        input logic d, input logic sen,
                        output logic [ROWS-1:0] wl_seen);
    wl_seen = '0;
    @(negedge clk);
    addr = a; din = d; sense_en = sen;
    rd_stb = kind[0]; wr_stb = kind[1];
    phi_pre = 1'b1;
    repeat (4) @(negedge clk);
    phi_pre = 1'b0;
    @(negedge clk);
    phi_eval = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1 wl_seen = wl_seen | wordline;
      @(negedge clk);
    end
    phi_eval = 1'b0;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0; sense_en = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ROWS-1:0] seen;
    int miss;
    repeat (3) @(negedge clk);
    check("R10 dout in reset", 32'(dout), 32'd0);
    check("R10 wordline in reset", 32'(wordline), 32'd0);
    rst_n = 1'b1;

    // Table walk.
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] kind;
      logic [AW-1:0] a;
      kind = VEC[v][12:11];
      a = VEC[v][10:4];
      access(kind, a, VEC[v][3], VEC[v][2], seen);
      check($sformatf("R6 vector %0d dout", v), 32'(dout), 32'(VEC[v][1]));
      if (kind == 2'd0)
        check($sformatf("R9 vector %0d no word line", v), 32'(seen), 32'd0);
      else
        check($sformatf("R1 vector %0d word line", v), 32'(seen),
              32'(1) << a[3:0]);
    end

    // Full-array pattern: write every address, then read each back.
    for (int a = 0; a < 128; a++) begin
      access(2'd2, AW'(a), pattern_bit(AW'(a)), 1'b1, seen);
    end
    miss = 0;
    for (int a = 0; a < 128; a++) begin
      access(2'd1, AW'(a), 1'b0, 1'b1, seen);
      check($sformatf("R1 R5 read addr %0h", a), 32'(dout),
            32'(pattern_bit(AW'(a))));
      if (seen != (ROWS'(1) << a[3:0])) miss++;
    end
    check("R1 word line per address", 32'(miss), 32'd0);

    // Precharge between alternating values (R4).
    access(2'd2, 7'h7f, 1'b1, 1'b1, seen);
    access(2'd2, 7'h70, 1'b0, 1'b1, seen);
    access(2'd1, 7'h7f, 1'b0, 1'b1, seen);
    check("R4 alternate read 1", 32'(dout), 32'd1);
    access(2'd1, 7'h70, 1'b0, 1'b1, seen);
    check("R4 alternate read 0", 32'(dout), 32'd0);

    // Reset in mid-run clears the array (R10).
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 wordline during reset", 32'(wordline), 32'd0);
    rst_n = 1'b1;
    access(2'd1, 7'h7f, 1'b0, 1'b1, seen);
    check("R10 cell cleared by reset", 32'(dout), 32'd0);

    check("R2 word lines one-hot", 32'(bad_r2), 32'd0);
    check("R3 word lines gated by phases", 32'(bad_r3), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule